// File: doc/BRIEF.md
# Multi-Coding Bus Decoder

This block sits at the receiving end of a low-transition bus. The sending side picks, word by word, one of four reversible bit transforms to cut switching activity, and sends a 2-bit selector alongside each coded word. The decoder reads that selector and applies the matching inverse to get back the original data word. Each of the four transforms is its own inverse, so the decoder applies the same operation that the selector names. The decoder needs no history: it never looks at earlier bus values.

Both the coded input and the decoded output are valid/ready streams with one register stage between them. A word is taken in on a clock edge where `enc_valid` and `enc_ready` are both high. It shows up on `dec_word` with `dec_valid` set in the next cycle. The output stays valid and unchanged until the sink raises `dec_ready`. While the output register holds a word the sink has not taken, `enc_ready` is low, so back-pressure reaches the source in the same cycle. When the register is empty, or is being drained in the current cycle, a new word can enter without a bubble.

Top module: `mcd_decoder`

## Requirements
- R1: Selector value 00 (full inversion): the decoded word is the bitwise complement of the coded word.
- R2: Selector value 01 (pair swap): bit 2k of the decoded word is bit 2k+1 of the coded word, and bit 2k+1 is bit 2k, for every pair k.
- R3: Selector value 10 (even inversion): bits at even positions are complemented (bit 0 is the LSB and counts as even, so the mask is 0x55 for 8 bits). Odd bits pass through unchanged.
- R4: Selector value 11 (odd inversion): bits at odd positions are complemented (mask 0xAA for 8 bits). Even bits pass through unchanged.
- R5: A word accepted on one clock edge appears on `dec_word` with `dec_valid` high right after the next edge, a latency of one cycle.
- R6: An active-low reset clears `dec_valid` and `dec_word` to zero at once and keeps them cleared while it is held.
- R7: While `dec_valid` is high and `dec_ready` is low, `enc_ready` is low and `dec_word` and `dec_valid` keep their values on the next edge.
- R8: A coded word offered while `enc_ready` is low is not accepted: the held output word does not change.
- R9: If `dec_ready` is high and no word is accepted, `dec_valid` is low after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_valid | input | 1 | A coded word is offered |
| enc_ready | output | 1 | Decoder can accept a word this cycle |
| enc_word | input | WIDTH | Coded bus word |
| enc_sel | input | 2 | Selector naming the transform that was applied |
| dec_valid | output | 1 | Decoded word is present |
| dec_ready | input | 1 | Sink takes the decoded word this cycle |
| dec_word | output | WIDTH | Recovered original word |

## Verification
The assertions assume that the source keeps `enc_word` and `enc_sel` meaningful whenever `enc_valid` is high, and that every selector value is legal, because all four 2-bit codes are defined. They also assume that the sink drives `dec_ready` to a known level on every cycle. The stimulus drives these inputs only between clock edges and never leaves them unknown after reset. It covers all four selectors with fixed and random words, and it toggles `dec_ready` at random so that stalls, offers ignored during a stall and empty cycles all occur, along with a reset in the middle of traffic.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  typedef enum logic [1:0] {
    SEL_FLIP_ALL  = 2'b00,
    SEL_PAIR_SWAP = 2'b01,
    SEL_FLIP_EVEN = 2'b10,
    SEL_FLIP_ODD  = 2'b11
  } mcd_sel_e;

endpackage

// File: rtl/mcd_pair_lane.sv
module mcd_pair_lane
  import mcd_pkg::*;
(
  input  logic [1:0] pair_in,
  input  mcd_sel_e   sel,
  output logic [1:0] pair_out
);

  // bit 0 of the pair is the even position, bit 1 the odd one
  always_comb begin
    unique case (sel)
      SEL_FLIP_ALL:  pair_out = ~pair_in;
      SEL_PAIR_SWAP: pair_out = {pair_in[0], pair_in[1]};
      SEL_FLIP_EVEN: pair_out = {pair_in[1], ~pair_in[0]};
      SEL_FLIP_ODD:  pair_out = {~pair_in[1], pair_in[0]};
      default:       pair_out = pair_in;
    endcase
  end

endmodule

// File: rtl/mcd_xform.sv
module mcd_xform
  import mcd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] word_in,
  input  mcd_sel_e         sel,
  output logic [WIDTH-1:0] word_out
);

  localparam int PAIRS = WIDTH / 2;

  if ((WIDTH % 2) != 0 || WIDTH < 2) begin : g_bad_width
    initial $error("mcd_xform: WIDTH must be even and at least 2");
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_lane
    mcd_pair_lane u_lane (
      .pair_in  (word_in[2*p +: 2]),
      .sel      (sel),
      .pair_out (word_out[2*p +: 2])
    );
  end

endmodule

// File: rtl/mcd_out_stage.sv
module mcd_out_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_word,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_word
);

  logic             held_valid;
  logic [WIDTH-1:0] held_word;
  logic             take;

  assign in_ready = !held_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held_word  <= '0;
    end else begin
      if (take) begin
        held_valid <= 1'b1;
        held_word  <= in_word;
      end else if (out_ready) begin
        held_valid <= 1'b0;
      end
    end
  end

  assign out_valid = held_valid;
  assign out_word  = held_word;

endmodule

// File: rtl/mcd_decoder.sv
module mcd_decoder
  import mcd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_valid,
  output logic             enc_ready,
  input  logic [WIDTH-1:0] enc_word,
  input  logic [1:0]       enc_sel,
  output logic             dec_valid,
  input  logic             dec_ready,
  output logic [WIDTH-1:0] dec_word
);

  mcd_sel_e         sel_q;
  logic [WIDTH-1:0] plain_word;

  assign sel_q = mcd_sel_e'(enc_sel);

  mcd_xform #(.WIDTH(WIDTH)) u_xform (
    .word_in  (enc_word),
    .sel      (sel_q),
    .word_out (plain_word)
  );

  mcd_out_stage #(.WIDTH(WIDTH)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (enc_valid),
    .in_ready  (enc_ready),
    .in_word   (plain_word),
    .out_valid (dec_valid),
    .out_ready (dec_ready),
    .out_word  (dec_word)
  );

endmodule

// File: rtl/mcd_decoder_chk.sv
module mcd_decoder_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enc_valid,
  input logic             enc_ready,
  input logic [WIDTH-1:0] enc_word,
  input logic [1:0]       enc_sel,
  input logic             dec_valid,
  input logic             dec_ready,
  input logic [WIDTH-1:0] dec_word
);

  logic [1:0]       last_sel;
  logic [WIDTH-1:0] reenc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_sel <= 2'b00;
    else if (enc_valid && enc_ready) last_sel <= enc_sel;
  end

  // applying the transform again to the output must give back the coded word
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      case (last_sel)
        2'b00:   reenc[i] = ~dec_word[i];
        2'b01:   reenc[i] = dec_word[i ^ 1];
        2'b10:   reenc[i] = dec_word[i] ^ ((i % 2) == 0);
        default: reenc[i] = dec_word[i] ^ ((i % 2) == 1);
      endcase
    end
  end

  AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_valid && enc_ready) |=> (dec_valid && reenc == $past(enc_word))); // R5

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!dec_valid && dec_word == '0)); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_word))); // R7

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |-> !enc_ready); // R8

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ready && !enc_valid) |=> !dec_valid); // R9

endmodule

bind mcd_decoder mcd_decoder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enc_valid (enc_valid),
  .enc_ready (enc_ready),
  .enc_word  (enc_word),
  .enc_sel   (enc_sel),
  .dec_valid (dec_valid),
  .dec_ready (dec_ready),
  .dec_word  (dec_word)
);

// File: tb/mcd_decoder_test.sv
`timescale 1ns/1ps
module mcd_decoder_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enc_valid = 1'b0;
  logic         enc_ready;
  logic [W-1:0] enc_word = '0;
  logic [1:0]   enc_sel = 2'b00;
  logic         dec_valid;
  logic         dec_ready = 1'b0;
  logic [W-1:0] dec_word;

  int checks = 0;
  int errors = 0;

  // reference state
  bit           m_valid = 1'b0;
  logic [W-1:0] m_word = '0;
  string        m_tag = "R5";
  bit           r8_pending = 1'b0;

  always #4 clk = ~clk;

  mcd_decoder #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .enc_valid(enc_valid), .enc_ready(enc_ready),
    .enc_word(enc_word), .enc_sel(enc_sel),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_word(dec_word)
  );

  function automatic logic [W-1:0] ref_decode(input logic [W-1:0] w, input logic [1:0] s);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      if (s == 2'd0)      r[i] = !w[i];
      else if (s == 2'd1) r[i] = (i % 2 == 0) ? w[i+1] : w[i-1];
      else if (s == 2'd2) r[i] = (i % 2 == 0) ? !w[i] : w[i];
      else                r[i] = (i % 2 == 1) ? !w[i] : w[i];
    end
    return r;
  endfunction

  function automatic string sel_tag(input logic [1:0] s);
    case (s)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic check_outputs();
    check(dec_valid === m_valid, m_valid ? "R5" : "R9", "dec_valid",
          {31'd0, dec_valid}, {31'd0, m_valid});
    if (m_valid) begin
      check(dec_word === m_word, m_tag, "dec_word", {24'd0, dec_word}, {24'd0, m_word});
      if (r8_pending)
        check(dec_word === m_word, "R8", "word after ignored offer",
              {24'd0, dec_word}, {24'd0, m_word});
    end
    r8_pending = 1'b0;
  endtask

  task automatic step(input bit v, input logic [W-1:0] w, input logic [1:0] s, input bit rdy);
    bit exp_rdy;
    @(negedge clk);
    check_outputs();
    enc_valid = v;
    enc_word  = w;
    enc_sel   = s;
    dec_ready = rdy;
    #1;
    exp_rdy = !m_valid || rdy;
    check(enc_ready === exp_rdy, "R7", "enc_ready", {31'd0, enc_ready}, {31'd0, exp_rdy});
    if (v && exp_rdy) begin
      m_valid = 1'b1;
      m_word  = ref_decode(w, s);
      m_tag   = sel_tag(s);
    end else begin
      if (v) r8_pending = 1'b1;
      if (m_valid && !rdy) m_tag = "R7";
      if (rdy) m_valid = 1'b0;
    end
  endtask

  task automatic reset_now();
    @(negedge clk);
    check_outputs();
    rst_n = 1'b0;
    enc_valid = 1'b0;
    m_valid = 1'b0;
    m_word = '0;
    #1;
    check(dec_valid === 1'b0, "R6", "dec_valid in reset", {31'd0, dec_valid}, 32'd0);
    check(dec_word === '0, "R6", "dec_word in reset", {24'd0, dec_word}, 32'd0);
    @(negedge clk);
    check(dec_valid === 1'b0 && dec_word === '0, "R6", "outputs held in reset",
          {23'd0, dec_valid, dec_word}, 32'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL R5 watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dec_valid === 1'b0 && dec_word === '0, "R6", "outputs after power-up reset",
          {23'd0, dec_valid, dec_word}, 32'd0);
    rst_n = 1'b1;

    // directed words per selector, sink always ready
    step(1'b1, 8'h6B, 2'd0, 1'b1);  // R1 -> 94
    step(1'b1, 8'h1B, 2'd1, 1'b1);  // R2 -> 27
    step(1'b1, 8'h00, 2'd2, 1'b1);  // R3 -> 55
    step(1'b1, 8'h00, 2'd3, 1'b1);  // R4 -> AA
    step(1'b1, 8'hFF, 2'd2, 1'b1);  // R3 -> AA
    step(1'b1, 8'hFF, 2'd3, 1'b1);  // R4 -> 55
    step(1'b1, 8'h80, 2'd1, 1'b1);  // R2 -> 40
    step(1'b0, 8'h00, 2'd0, 1'b1);  // R9 drain
    step(1'b0, 8'h00, 2'd0, 1'b1);

    // stall with offers that must be ignored (R7, R8)
    step(1'b1, 8'h3C, 2'd0, 1'b0);
    step(1'b1, 8'h12, 2'd1, 1'b0);
    step(1'b1, 8'h34, 2'd2, 1'b0);
    step(1'b1, 8'h56, 2'd3, 1'b1);
    step(1'b0, 8'h00, 2'd0, 1'b1);

    // random traffic, every selector, random back-pressure
    for (int n = 0; n < 2000; n++) begin
      step(($urandom % 4) != 0, 8'($urandom), 2'($urandom), ($urandom % 3) != 0);
      if (n == 1000) reset_now();
    end

    step(1'b0, 8'h00, 2'd0, 1'b1);
    step(1'b0, 8'h00, 2'd0, 1'b1);
    @(negedge clk);
    check_outputs();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule